// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller with Threshold-Gated Interrupt

This block holds the digital sequencing of a 10-bit successive-approximation converter that serves 12 analog channels. A software start pulse or an external trigger launches a conversion on the requested channel. The block first holds its sample enable for a programmable number of cycles. It then resolves the result from the most significant bit down to the least significant bit. For each trial it presents a code to an external compare DAC and reads back one comparator bit. The sample-and-hold, the DAC and the comparator sit outside the block and are reached only through ports.

Each finished result goes into a 16-bit register kept per channel, left-justified so that the low six bits read as zero. Any channel can be read back combinationally through a read-select port. An optional compare stage weighs the top byte of the new result against an 8-bit threshold. That check decides whether the end-of-conversion interrupt pulse is raised. With the compare off, every conversion raises the pulse.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset `busy` and `irq` are low and every channel's result reads as 0x0000.
- R2: While idle, a high `sw_start` or `hw_trig` at a clock edge starts a conversion on `ch_sel`, provided `ch_sel` is below 12. A start naming channel 12 or higher is ignored.
- R3: The sample phase lasts `smp_cycles`+1 cycles. During it `sample_en` is high and `ana_ch` shows the latched channel.
- R4: Ten trial cycles follow, one per bit, from bit 9 down to bit 0. In each one `dac_code` is the bits decided so far, plus a 1 at the current bit, plus zeros below it. A `cmp_in` of 1 (input at or above the code) keeps that bit.
- R5: After the final trial, `rd_data` for that channel is {result[9:0], 6'b000000}. Every other channel keeps its value.
- R6: `busy` is high from the cycle after the start edge through the last trial cycle, which is `smp_cycles`+11 cycles. It is low in the cycle in which the new result is readable.
- R7: A start request made while `busy` is high is ignored. The latched channel does not change, and no new conversion follows the current one.
- R8: With `cmp_en` low, `irq` pulses after every completed conversion.
- R9: With `cmp_en` high, the stored result bits 15:8 are weighed against `thresh`. `cmp_mode`=0 raises `irq` only if they are greater than or equal to `thresh`. `cmp_mode`=1 raises it only if they are less than `thresh`.
- R10: `irq` is a one-cycle pulse in the first cycle that `busy` is low after a conversion, and it appears at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_start | input | 1 | Software start request |
| hw_trig | input | 1 | External hardware start request |
| ch_sel | input | 4 | Channel to convert, taken at start |
| smp_cycles | input | 4 | Sample phase length minus one |
| cmp_en | input | 1 | Enables threshold gating of the interrupt |
| cmp_mode | input | 1 | 0: at-or-above threshold, 1: below threshold |
| thresh | input | 8 | Threshold for result bits 15:8 |
| cmp_in | input | 1 | Comparator output, 1 when input is at or above `dac_code` |
| ana_ch | output | 4 | Channel presented to the input multiplexer |
| sample_en | output | 1 | Sample-and-hold acquire enable |
| dac_code | output | 10 | Trial code to the compare DAC |
| busy | output | 1 | Conversion in progress |
| irq | output | 1 | End-of-conversion interrupt pulse |
| rd_ch | input | 4 | Channel whose result is read |
| rd_data | output | 16 | Left-justified result of `rd_ch` |

## Verification
The converter is tried with inputs of zero, full scale and the two alternating patterns 0x2AA and 0x155. Each of these fails a different mistake in the bit order or in the keep/drop rule. A value whose top byte equals the threshold, and the same value against the threshold one above it, is run in both compare modes. Those runs separate the at-or-above condition from the below condition exactly at the boundary. Channels 0 and 11, an out-of-range channel, a hardware-triggered start, the shortest and longest sample phases, and a start injected mid-conversion cover channel latching, phase length and start filtering. A final sweep of all channels confirms that no conversion touched another channel's register.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SAMPLE = 2'd1,
      ST_CONV   = 2'd2
   } sar_state_e;
endpackage

// File: rtl/sar_seq.sv
module sar_seq
   import sar_adc_pkg::*;
#(
   parameter int RES_W = 10,
   parameter int NCH   = 12,
   parameter int CH_W  = 4,
   parameter int SMP_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_req,
   input  logic [CH_W-1:0]  ch_req,
   input  logic [SMP_W-1:0] smp_cycles,
   input  logic             cmp_in,
   output logic             busy,
   output logic             sample_en,
   output logic [CH_W-1:0]  ana_ch,
   output logic [RES_W-1:0] dac_code,
   output logic             done,
   output logic [RES_W-1:0] result
);
   localparam int BIT_W = (RES_W > 1) ? $clog2(RES_W) : 1;
   localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(RES_W - 1);

   sar_state_e       state_q;
   logic [SMP_W-1:0] cnt_q;
   logic [BIT_W-1:0] bit_q;
   logic [RES_W-1:0] sar_q;
   logic [CH_W-1:0]  ch_q;
   logic [RES_W-1:0] trial_bit;
   logic [RES_W-1:0] sar_next;
   logic             ch_ok;

   assign ch_ok     = (int'(ch_req) < NCH);
   assign trial_bit = {{(RES_W-1){1'b0}}, 1'b1} << bit_q;
   assign sar_next  = cmp_in ? (sar_q | trial_bit) : sar_q;
   assign dac_code  = (state_q == ST_CONV) ? (sar_q | trial_bit) : '0;
   assign done      = (state_q == ST_CONV) && (bit_q == '0);
   assign result    = sar_next;
   assign busy      = (state_q != ST_IDLE);
   assign sample_en = (state_q == ST_SAMPLE);
   assign ana_ch    = ch_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         bit_q   <= '0;
         sar_q   <= '0;
         ch_q    <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start_req && ch_ok) begin
                  state_q <= ST_SAMPLE;
                  cnt_q   <= smp_cycles;
                  ch_q    <= ch_req;
               end
            end
            ST_SAMPLE: begin
               if (cnt_q == '0) begin
                  state_q <= ST_CONV;
                  bit_q   <= TOP_BIT;
                  sar_q   <= '0;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            ST_CONV: begin
               sar_q <= sar_next;
               if (bit_q == '0) state_q <= ST_IDLE;
               else             bit_q   <= bit_q - 1'b1;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R4
   trial_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_CONV) |-> ((dac_code & (trial_bit - 1'b1)) == '0) && ((dac_code & trial_bit) != '0));

   // R7
   ch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(ana_ch));
endmodule

// File: rtl/sar_result_bank.sv
module sar_result_bank #(
   parameter int RES_W = 10,
   parameter int REG_W = 16,
   parameter int NCH   = 12,
   parameter int CH_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CH_W-1:0]  wr_ch,
   input  logic [RES_W-1:0] wr_val,
   input  logic [CH_W-1:0]  rd_ch,
   output logic [REG_W-1:0] rd_data
);
   localparam int PAD_W = REG_W - RES_W;

   logic [RES_W-1:0] slot_q [NCH];
   logic [RES_W-1:0] rd_raw;

   for (genvar c = 0; c < NCH; c++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                  slot_q[c] <= '0;
         else if (wr_en && (int'(wr_ch) == c))        slot_q[c] <= wr_val;
      end
   end

   assign rd_raw = (int'(rd_ch) < NCH) ? slot_q[rd_ch] : '0;

   if (PAD_W > 0) begin : g_pad
      assign rd_data = {rd_raw, {PAD_W{1'b0}}};
   end else begin : g_nopad
      assign rd_data = rd_raw;
   end
endmodule

// File: rtl/sar_thresh_gate.sv
module sar_thresh_gate #(
   parameter int THR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             done,
   input  logic [THR_W-1:0] res_hi,
   input  logic             cmp_en,
   input  logic             cmp_mode,
   input  logic [THR_W-1:0] thresh,
   output logic             irq
);
   logic at_or_above;
   logic pass;

   assign at_or_above = (res_hi >= thresh);
   assign pass        = !cmp_en || (cmp_mode ? !at_or_above : at_or_above);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= done && pass;
   end

   // R10
   irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
   parameter int RES_W = 10,
   parameter int REG_W = 16,
   parameter int NCH   = 12,
   parameter int THR_W = 8,
   parameter int SMP_W = 4,
   parameter int CH_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sw_start,
   input  logic             hw_trig,
   input  logic [CH_W-1:0]  ch_sel,
   input  logic [SMP_W-1:0] smp_cycles,
   input  logic             cmp_en,
   input  logic             cmp_mode,
   input  logic [THR_W-1:0] thresh,
   input  logic             cmp_in,
   output logic [CH_W-1:0]  ana_ch,
   output logic             sample_en,
   output logic [RES_W-1:0] dac_code,
   output logic             busy,
   output logic             irq,
   input  logic [CH_W-1:0]  rd_ch,
   output logic [REG_W-1:0] rd_data
);
   if (REG_W < RES_W) begin : g_bad_reg_w
      $error("REG_W must be at least RES_W");
   end
   if (THR_W > RES_W) begin : g_bad_thr_w
      $error("THR_W must not exceed RES_W");
   end
   if ((1 << CH_W) < NCH) begin : g_bad_ch_w
      $error("CH_W too narrow for NCH");
   end

   logic             done;
   logic [RES_W-1:0] result;

   sar_seq #(.RES_W(RES_W), .NCH(NCH), .CH_W(CH_W), .SMP_W(SMP_W)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .start_req(sw_start | hw_trig), .ch_req(ch_sel), .smp_cycles(smp_cycles),
      .cmp_in(cmp_in), .busy(busy), .sample_en(sample_en), .ana_ch(ana_ch),
      .dac_code(dac_code), .done(done), .result(result)
   );

   sar_result_bank #(.RES_W(RES_W), .REG_W(REG_W), .NCH(NCH), .CH_W(CH_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_en(done), .wr_ch(ana_ch), .wr_val(result),
      .rd_ch(rd_ch), .rd_data(rd_data)
   );

   sar_thresh_gate #(.THR_W(THR_W)) u_gate (
      .clk(clk), .rst_n(rst_n), .done(done),
      .res_hi(result[RES_W-1 -: THR_W]),
      .cmp_en(cmp_en), .cmp_mode(cmp_mode), .thresh(thresh), .irq(irq)
   );

   // R10
   irq_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (!busy && $past(busy)));

   // R6
   busy_from_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> sample_en);
endmodule

// File: tb/tb_sar_adc_ctrl.sv
module tb_sar_adc_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sw_start = 1'b0, hw_trig = 1'b0;
   logic [3:0] ch_sel = '0, smp_cycles = '0, rd_ch = '0;
   logic       cmp_en = 1'b0, cmp_mode = 1'b0;
   logic [7:0] thresh = '0;
   logic       cmp_in;
   logic [3:0] ana_ch;
   logic       sample_en, busy, irq;
   logic [9:0] dac_code;
   logic [15:0] rd_data;
   int         vin_q = 0;

   int checks = 0, errors = 0;

   typedef struct { int ch; int val; bit irq; } exp_t;
   exp_t exp_q[$];
   int   bank_model [12];

   always #4 clk = ~clk;

   assign cmp_in = (vin_q >= int'(dac_code));

   sar_adc_ctrl dut (
      .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .hw_trig(hw_trig),
      .ch_sel(ch_sel), .smp_cycles(smp_cycles), .cmp_en(cmp_en), .cmp_mode(cmp_mode),
      .thresh(thresh), .cmp_in(cmp_in), .ana_ch(ana_ch), .sample_en(sample_en),
      .dac_code(dac_code), .busy(busy), .irq(irq), .rd_ch(rd_ch), .rd_data(rd_data)
   );

   task automatic check(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   // driver: launches one conversion, checks phase timing and trial codes
   task automatic run_conv(input int ch, input int vin, input int smp, input bit en,
                           input bit mode, input int thr, input bit use_hw, input bit inject);
      int busy_cnt = 0, smp_cnt = 0, dec = 0, b = 9;
      bit ch_ok = 1, dac_ok = 1;
      exp_t e;
      @(negedge clk);
      ch_sel = 4'(ch); smp_cycles = 4'(smp); cmp_en = en; cmp_mode = mode;
      thresh = 8'(thr); vin_q = vin;
      sw_start = !use_hw; hw_trig = use_hw;
      e.ch = ch; e.val = vin;
      e.irq = !en || (mode ? ((vin >> 2) < thr) : ((vin >> 2) >= thr));
      exp_q.push_back(e);
      @(negedge clk);
      sw_start = 1'b0; hw_trig = 1'b0;
      check(busy == 1'b1, "R2 busy after start", int'(busy), 1);
      while (busy && busy_cnt < 100) begin
         busy_cnt++;
         if (ana_ch != 4'(ch)) ch_ok = 0;
         if (sample_en) smp_cnt++;
         else begin
            if (int'(dac_code) != (dec | (1 << b))) dac_ok = 0;
            if (vin >= (dec | (1 << b))) dec = dec | (1 << b);
            b--;
         end
         if (inject && busy_cnt == 3) begin sw_start = 1'b1; ch_sel = 4'((ch + 1) % 12); end
         if (inject && busy_cnt == 4) sw_start = 1'b0;
         @(negedge clk);
      end
      sw_start = 1'b0;
      check(busy_cnt == smp + 11, "R6 busy length", busy_cnt, smp + 11);
      check(smp_cnt == smp + 1, "R3 sample length", smp_cnt, smp + 1);
      check(ch_ok, "R3 ana_ch held (R7)", int'(ana_ch), ch);
      check(dac_ok, "R4 trial code sequence", 0, 1);
      @(negedge clk);
      check(busy == 1'b0, "R7 no restart after busy-time start", int'(busy), 0);
   endtask

   // monitor: pops expected items at each conversion end
   initial begin
      bit prev_busy = 0;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (prev_busy && !busy) begin
               exp_t e;
               if (exp_q.size() == 0) begin
                  check(0, "R10 unexpected completion", 1, 0);
               end else begin
                  e = exp_q.pop_front();
                  check(irq == e.irq, e.irq ? "R8/R9 irq expected" : "R9 irq suppressed",
                        int'(irq), int'(e.irq));
                  rd_ch = 4'(e.ch);
                  #1;
                  check(rd_data == 16'(e.val << 6), "R5 stored result", int'(rd_data), e.val << 6);
                  bank_model[e.ch] = e.val << 6;
               end
            end else begin
               check(irq == 1'b0, "R10 irq only at end", int'(irq), 0);
            end
            prev_busy = busy;
         end
      end
   end

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      for (int i = 0; i < 12; i++) bank_model[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy == 1'b0 && irq == 1'b0, "R1 idle after reset", int'({busy, irq}), 0);
      for (int i = 0; i < 12; i++) begin
         rd_ch = 4'(i); #1;
         check(rd_data == 16'h0, "R1 result cleared", int'(rd_data), 0);
      end

      run_conv(0, 0, 0, 0, 0, 0, 0, 0);
      run_conv(11, 1023, 15, 0, 0, 0, 1, 0);
      run_conv(5, 'h2AA, 3, 0, 0, 0, 0, 1);
      run_conv(3, 'h155, 1, 0, 0, 0, 1, 1);
      run_conv(7, 'h1F0, 2, 1, 0, 'h7C, 0, 0);
      run_conv(7, 'h1F0, 2, 1, 0, 'h7D, 0, 0);
      run_conv(8, 'h1F3, 0, 1, 1, 'h7C, 0, 0);
      run_conv(8, 'h1F3, 0, 1, 1, 'h7D, 0, 0);

      // R2 out-of-range channel is ignored
      @(negedge clk);
      ch_sel = 4'd12; sw_start = 1'b1;
      @(negedge clk);
      sw_start = 1'b0;
      check(busy == 1'b0, "R2 channel 12 ignored", int'(busy), 0);
      @(negedge clk);
      check(busy == 1'b0, "R2 channel 12 stays idle", int'(busy), 0);

      run_conv(0, 'h200, 4, 0, 0, 0, 0, 0);

      repeat (3) @(negedge clk);
      for (int i = 0; i < 12; i++) begin
         rd_ch = 4'(i); #1;
         check(int'(rd_data) == bank_model[i], "R5 other channels untouched", int'(rd_data), bank_model[i]);
      end
      check(exp_q.size() == 0, "R10 all conversions completed", exp_q.size(), 0);
      finish_run();
   end
endmodule